// File: doc/BRIEF.md
# Edge-Driven Pulse Counter Unit

This block counts transitions on one external pulse line, using a signed two's-complement tally. The pulse line and a companion control line both pass through a synchroniser. Each edge of the synchronised pulse line is then turned into a step of plus one, minus one or nothing. Two separate mode fields choose the step, one for rising edges and one for falling edges. The level of the control line then adjusts that step through one of two further mode fields, one used while the control line is low and one while it is high. Each of these fields either keeps the step, reverses its direction, or suppresses it.

The tally has a signed upper limit and a signed lower limit. When a step lands exactly on either limit, the tally returns to zero and a one-cycle limit event is raised. Every step is also compared against five values: both limits, zero and two free thresholds. A match on any of them sets a sticky interrupt flag, which stays set until software pulses a clear input. All configuration arrives on plain input ports, and the count is visible at all times.

Top module: `pulse_count_unit`

## Requirements
- R1: A synchronous active-high `rst` forces `count_o` to 0, `irq_o` to 0 and `limit_evt_o` to 0, and clears the synchroniser and edge history.
- R2: The rising-edge mode field selects the step taken on a rising edge of the synchronised pulse line: 1 = +1, 2 = -1, 0 or 3 = no step.
- R3: The falling-edge mode field uses the same encoding (1 = +1, 2 = -1, 0 or 3 = no step) for falling edges. It is independent of the rising-edge field.
- R4: The control mode field in force is `ctrl_lo_mode` while the synchronised control line is 0 and `ctrl_hi_mode` while it is 1. Its encoding is: 0 or 3 = keep the step, 1 = reverse +1 and -1, 2 = suppress any step.
- R5: A +1 step whose result equals `limit_hi` loads 0 instead. `limit_evt_o` is then 1 for exactly the following cycle.
- R6: A -1 step whose result equals `limit_lo` loads 0 instead. `limit_evt_o` is then 1 for exactly the following cycle.
- R7: A step whose result (before any reload to zero) equals `limit_hi`, `limit_lo`, 0, `thresh_a` or `thresh_b` sets `irq_o`. Once set, `irq_o` stays set.
- R8: A one-cycle `irq_clr` clears `irq_o`. If a matching step happens in the same cycle, the set wins and `irq_o` stays 1.
- R9: The count changes by at most one step per clock. A pulse-line edge is reflected in `count_o` on the third rising clock edge after the input changes.
- R10: A pulse line held at a constant level produces no further steps, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous pulse line whose edges are counted |
| ctrl_in | input | 1 | Asynchronous control line that selects the control mode field |
| rise_mode | input | 2 | Step on rising edge (R2 encoding) |
| fall_mode | input | 2 | Step on falling edge (R3 encoding) |
| ctrl_lo_mode | input | 2 | Step adjustment while the control line is low (R4 encoding) |
| ctrl_hi_mode | input | 2 | Step adjustment while the control line is high (R4 encoding) |
| limit_hi | input | CNT_W | Signed upper limit |
| limit_lo | input | CNT_W | Signed lower limit |
| thresh_a | input | CNT_W | Signed comparison threshold A |
| thresh_b | input | CNT_W | Signed comparison threshold B |
| irq_clr | input | 1 | One-cycle clear of the interrupt flag |
| count_o | output | CNT_W | Signed running count |
| limit_evt_o | output | 1 | One-cycle pulse after a limit reload |
| irq_o | output | 1 | Sticky comparator-match interrupt |

## Verification
The hardest situation to reach from the ports is a clear pulse that arrives in the same cycle as a step that sets the interrupt. The input passes through the synchroniser and the edge history before any step is taken, so the step cannot be seen directly. The stimulus therefore counts clock edges from the moment the pulse line rises. It raises `irq_clr` for exactly the cycle whose closing edge applies the step, which lands the tally on a threshold. Limit reloads are reached in the same way: a short limit is programmed and the exact number of edges is applied to hit it.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  localparam logic [1:0] EDGE_INC   = 2'd1;
  localparam logic [1:0] EDGE_DEC   = 2'd2;
  localparam logic [1:0] CTRL_FLIP  = 2'd1;
  localparam logic [1:0] CTRL_BLOCK = 2'd2;

  function automatic step_e edge_step(input logic [1:0] mode);
    case (mode)
      EDGE_INC: edge_step = STEP_UP;
      EDGE_DEC: edge_step = STEP_DOWN;
      default:  edge_step = STEP_NONE;
    endcase
  endfunction

  function automatic step_e ctrl_apply(input step_e s, input logic [1:0] mode);
    case (mode)
      CTRL_FLIP: begin
        case (s)
          STEP_UP:   ctrl_apply = STEP_DOWN;
          STEP_DOWN: ctrl_apply = STEP_UP;
          default:   ctrl_apply = STEP_NONE;
        endcase
      end
      CTRL_BLOCK: ctrl_apply = STEP_NONE;
      default:    ctrl_apply = s;
    endcase
  endfunction

endpackage

// File: rtl/pcu_sync.sv
module pcu_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pcu_edge_action.sv
module pcu_edge_action
  import pcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sig_s,
  input  logic       ctrl_s,
  input  logic [1:0] rise_mode,
  input  logic [1:0] fall_mode,
  input  logic [1:0] ctrl_lo_mode,
  input  logic [1:0] ctrl_hi_mode,
  output step_e      step_o
);

  logic  prev_q;
  logic  is_rise;
  logic  is_fall;
  step_e raw_step;
  logic [1:0] ctrl_mode;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_s;
  end

  always_comb begin
    is_rise   = sig_s & ~prev_q;
    is_fall   = ~sig_s & prev_q;
    if (is_rise)      raw_step = edge_step(rise_mode);
    else if (is_fall) raw_step = edge_step(fall_mode);
    else              raw_step = STEP_NONE;
    ctrl_mode = ctrl_s ? ctrl_hi_mode : ctrl_lo_mode;
    step_o    = ctrl_apply(raw_step, ctrl_mode);
  end

endmodule

// File: rtl/pcu_counter.sv
module pcu_counter
  import pcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  step_e                   step_i,
  input  logic signed [CNT_W-1:0] limit_hi,
  input  logic signed [CNT_W-1:0] limit_lo,
  input  logic signed [CNT_W-1:0] thresh_a,
  input  logic signed [CNT_W-1:0] thresh_b,
  input  logic                    irq_clr,
  output logic signed [CNT_W-1:0] count_o,
  output logic                    limit_evt_o,
  output logic                    irq_o
);

  localparam int NCMP = 5;
  localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

  logic signed [CNT_W-1:0] cmp_val [NCMP];
  logic [NCMP-1:0]         hit;
  logic signed [CNT_W-1:0] next_v;
  logic                    moving;
  logic                    wrap;
  logic                    hit_any;

  always_comb begin
    cmp_val[0] = limit_hi;
    cmp_val[1] = limit_lo;
    cmp_val[2] = '0;
    cmp_val[3] = thresh_a;
    cmp_val[4] = thresh_b;
  end

  always_comb begin
    moving = (step_i != STEP_NONE);
    next_v = (step_i == STEP_UP) ? count_o + ONE : count_o - ONE;
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign hit[i] = (next_v == cmp_val[i]);
  end

  always_comb begin
    hit_any = moving && (|hit);
    wrap    = ((step_i == STEP_UP)   && (next_v == limit_hi)) ||
              ((step_i == STEP_DOWN) && (next_v == limit_lo));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o     <= '0;
      limit_evt_o <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      limit_evt_o <= wrap;
      if (moving) count_o <= wrap ? '0 : next_v;
      if (hit_any)      irq_o <= 1'b1;
      else if (irq_clr) irq_o <= 1'b0;
    end
  end

endmodule

// File: rtl/pulse_count_unit.sv
module pulse_count_unit
  import pcu_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sig_in,
  input  logic                    ctrl_in,
  input  logic [1:0]              rise_mode,
  input  logic [1:0]              fall_mode,
  input  logic [1:0]              ctrl_lo_mode,
  input  logic [1:0]              ctrl_hi_mode,
  input  logic signed [CNT_W-1:0] limit_hi,
  input  logic signed [CNT_W-1:0] limit_lo,
  input  logic signed [CNT_W-1:0] thresh_a,
  input  logic signed [CNT_W-1:0] thresh_b,
  input  logic                    irq_clr,
  output logic signed [CNT_W-1:0] count_o,
  output logic                    limit_evt_o,
  output logic                    irq_o
);

  logic [1:0] sync_w;
  step_e      step_w;

  pcu_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ctrl_in, sig_in}),
    .q_o (sync_w)
  );

  pcu_edge_action u_edge (
    .clk          (clk),
    .rst          (rst),
    .sig_s        (sync_w[0]),
    .ctrl_s       (sync_w[1]),
    .rise_mode    (rise_mode),
    .fall_mode    (fall_mode),
    .ctrl_lo_mode (ctrl_lo_mode),
    .ctrl_hi_mode (ctrl_hi_mode),
    .step_o       (step_w)
  );

  pcu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .step_i      (step_w),
    .limit_hi    (limit_hi),
    .limit_lo    (limit_lo),
    .thresh_a    (thresh_a),
    .thresh_b    (thresh_b),
    .irq_clr     (irq_clr),
    .count_o     (count_o),
    .limit_evt_o (limit_evt_o),
    .irq_o       (irq_o)
  );

endmodule

// File: rtl/pcu_checks.sv
module pcu_checks
  import pcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input step_e                   step_v,
  input logic                    irq_clr,
  input logic signed [CNT_W-1:0] count_o,
  input logic                    limit_evt_o,
  input logic                    irq_o
);

  localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(count_o) |-> (count_o == $past(count_o) + ONE ||
                           count_o == $past(count_o) - ONE ||
                           count_o == '0)); // R9

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
    (step_v == STEP_NONE) |=> $stable(count_o)); // R10

  AST_EVT_ZERO: assert property (@(posedge clk) disable iff (rst)
    limit_evt_o |-> (count_o == '0)); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_clr) |=> irq_o); // R7

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && step_v == STEP_NONE) |=> !irq_o); // R8

endmodule

bind pulse_count_unit pcu_checks #(.CNT_W(CNT_W)) u_pcu_checks (
  .clk         (clk),
  .rst         (rst),
  .step_v      (step_w),
  .irq_clr     (irq_clr),
  .count_o     (count_o),
  .limit_evt_o (limit_evt_o),
  .irq_o       (irq_o)
);

// File: tb/test_pulse_count_unit.sv
module test_pulse_count_unit;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_in = 1'b0, ctrl_in = 1'b0, irq_clr = 1'b0;
  logic [1:0] rise_mode = 2'd0, fall_mode = 2'd0;
  logic [1:0] ctrl_lo_mode = 2'd0, ctrl_hi_mode = 2'd0;
  logic signed [15:0] limit_hi = 16'sd100, limit_lo = -16'sd100;
  logic signed [15:0] thresh_a = 16'sd90, thresh_b = 16'sd91;
  logic signed [15:0] count_o;
  logic limit_evt_o, irq_o;

  int checks = 0;
  int errors = 0;
  int evt_cnt = 0;

  always #10 clk = ~clk;

  pulse_count_unit i_pulse_count_unit (
    .clk(clk), .rst(rst), .sig_in(sig_in), .ctrl_in(ctrl_in),
    .rise_mode(rise_mode), .fall_mode(fall_mode),
    .ctrl_lo_mode(ctrl_lo_mode), .ctrl_hi_mode(ctrl_hi_mode),
    .limit_hi(limit_hi), .limit_lo(limit_lo),
    .thresh_a(thresh_a), .thresh_b(thresh_b), .irq_clr(irq_clr),
    .count_o(count_o), .limit_evt_o(limit_evt_o), .irq_o(irq_o)
  );

  always @(negedge clk) if (!rst && limit_evt_o) evt_cnt++;

  // rise[11:10] fall[9:8] ctrl_lo[7:6] ctrl_hi[5:4] ctrl[3] delta-per-pulse[2:0]
  localparam int NVEC = 16;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd1, 2'd0, 2'd0, 2'd0, 1'b0, 3'b001},
    {2'd2, 2'd0, 2'd0, 2'd0, 1'b0, 3'b111},
    {2'd3, 2'd0, 2'd0, 2'd0, 1'b0, 3'b000},
    {2'd0, 2'd1, 2'd0, 2'd0, 1'b0, 3'b001},
    {2'd0, 2'd2, 2'd0, 2'd0, 1'b0, 3'b111},
    {2'd1, 2'd1, 2'd0, 2'd0, 1'b0, 3'b010},
    {2'd1, 2'd2, 2'd0, 2'd0, 1'b0, 3'b000},
    {2'd1, 2'd0, 2'd1, 2'd0, 1'b0, 3'b111},
    {2'd2, 2'd0, 2'd1, 2'd0, 1'b0, 3'b001},
    {2'd1, 2'd0, 2'd2, 2'd0, 1'b0, 3'b000},
    {2'd1, 2'd0, 2'd0, 2'd1, 1'b1, 3'b111},
    {2'd1, 2'd0, 2'd1, 2'd0, 1'b1, 3'b001},
    {2'd1, 2'd0, 2'd0, 2'd2, 1'b1, 3'b000},
    {2'd1, 2'd0, 2'd3, 2'd0, 1'b0, 3'b001},
    {2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 3'b000},
    {2'd2, 2'd2, 2'd0, 2'd1, 1'b1, 3'b010}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); sig_in = 1'b1;
    repeat (4) @(negedge clk);
    sig_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, from a nonzero count
    rise_mode = 2'd1;
    do_reset();
    pulse(); pulse();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 count", int'(count_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 evt", int'(limit_evt_o), 0);
    rst = 1'b0;

    // Table walk: R2 R3 R4 mode encodings
    for (int v = 0; v < NVEC; v++) begin
      rise_mode    = VEC[v][11:10];
      fall_mode    = VEC[v][9:8];
      ctrl_lo_mode = VEC[v][7:6];
      ctrl_hi_mode = VEC[v][5:4];
      ctrl_in      = VEC[v][3];
      do_reset();
      pulse(); pulse();
      chk($sformatf("R2/R3/R4 vec %0d", v), int'(count_o),
          2 * int'($signed(VEC[v][2:0])));
    end
    ctrl_in = 1'b0; rise_mode = 2'd1; fall_mode = 2'd0;
    ctrl_lo_mode = 2'd0; ctrl_hi_mode = 2'd0;

    // R9: latency of exactly three clock edges
    do_reset();
    @(negedge clk); sig_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 before third edge", int'(count_o), 0);
    @(negedge clk);
    chk("R9 at third edge", int'(count_o), 1);
    // R10: held level gives no more steps
    repeat (20) @(negedge clk);
    chk("R10 held high", int'(count_o), 1);
    sig_in = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 held low", int'(count_o), 1);

    // R5: high limit reload
    limit_hi = 16'sd5;
    do_reset();
    evt_cnt = 0;
    repeat (4) pulse();
    chk("R5 below limit", int'(count_o), 4);
    chk("R5 no event yet", evt_cnt, 0);
    pulse();
    chk("R5 reload", int'(count_o), 0);
    chk("R5 one event", evt_cnt, 1);
    limit_hi = 16'sd100;

    // R6: low limit reload
    limit_lo = -16'sd3; rise_mode = 2'd2;
    do_reset();
    evt_cnt = 0;
    repeat (2) pulse();
    chk("R6 below limit", int'(count_o), -2);
    pulse();
    chk("R6 reload", int'(count_o), 0);
    chk("R6 one event", evt_cnt, 1);
    limit_lo = -16'sd100;

    // R7: zero comparator (-1 back to 0)
    do_reset();
    pulse();
    chk("R7 no match at -1", int'(irq_o), 0);
    rise_mode = 2'd1;
    pulse();
    chk("R7 zero match", int'(irq_o), 1);

    // R7 / R8: thresholds, sticky, clear, set wins
    thresh_a = 16'sd2; thresh_b = 16'sd3;
    do_reset();
    pulse();
    chk("R7 no match at 1", int'(irq_o), 0);
    pulse();
    chk("R7 thresh_a match", int'(irq_o), 1);
    repeat (5) @(negedge clk);
    chk("R7 sticky", int'(irq_o), 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R8 clear", int'(irq_o), 0);
    sig_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R8 set wins count", int'(count_o), 3);
    chk("R8 set wins irq", int'(irq_o), 1);
    sig_in = 1'b0;
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule